// File: doc/BRIEF.md
# Raster-Op Rectangle Blit Engine

This block moves a rectangle of pixels inside a linear pixel memory. For every destination pixel it reads one source pixel and the current destination pixel, merges the two through one of sixteen fixed raster operations, and writes the result back. Software fills in a small set of 12-bit registers: source and destination addresses (24 bits each, split into two halves), width, height, row pitch, operation code, transparency colour and a control word. It then launches the copy, either by setting the launch bit in the control word or, when quick launch is armed, simply by writing the upper half of the destination address.

The engine talks to memory through a single synchronous port. A read returns its data in the cycle after the request. Pixels are handled strictly one after another: source read, destination read, optional write. So overlapping rectangles give the same result as a sequential copy, and the traversal direction decides which overlap is safe. A completion interrupt, a busy indication and an optional write-back of the final destination address finish the job.

Top module: `rop_blit_engine`

## Requirements
- R1: The register map is as follows: 0 control, 1 source bits 11:0, 2 source bits 23:12, 3 destination bits 11:0, 4 destination bits 23:12, 5 width, 6 height, 7 row pitch, 8 operation code (bits 3:0), 9 transparency colour. Each register reads back on `reg_rdata` at the same address. Control reads back bits 5:0 as written and bit 11 as busy.
- R2: The result is chosen by the operation code with S = source and D = destination: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 all ones.
- R3: With control bit 0 clear, pixels are visited row by row from the programmed addresses. Each step within a row adds 1 to the address, and each new row adds the pitch to the start of the row. The same rule applies to source and destination.
- R4: With control bit 0 set, the programmed addresses are those of the first pixel visited (bottom right). Each step within a row subtracts 1, and each new row subtracts the pitch.
- R5: Each pixel reads its source, then its destination, and writes its result before the next pixel is read. Overlapping rectangles therefore give the result of a sequential pixel-by-pixel copy.
- R6: Writing control with bit 11 set while idle starts the blit. `busy` and control bit 11 stay 1 until the last pixel is done. Memory is requested only while busy.
- R7: With control bit 4 set, a write to register 4 while idle stores the new value and starts the blit from it.
- R8: With control bit 1 set, a pixel whose destination equals the low bits of the transparency colour is skipped. Setting control bit 2 inverts this, so only matching pixels are written.
- R9: On completion `irq` rises if control bit 5 is set. It stays high until the next control write.
- R10: With control bit 3 set, completion loads the destination registers with the address of the last pixel written plus 1 (forward) or minus 1 (reverse). Otherwise they are unchanged.
- R11: A width or height of zero completes the blit with no memory access.
- R12: Register writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data at reg_addr |
| busy | output | 1 | Blit in progress |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when set, read otherwise |
| mem_addr | output | 24 | Memory pixel address |
| mem_wdata | output | PW | Pixel write data |
| mem_rdata | input | PW | Pixel read data, one cycle after request |

## Verification
Two functions can fall in the same cycle: a register write that launches the blit and the storing of that write. In quick-launch mode the upper destination half is both captured and used as the start address on one clock edge. The bench drives this in about half of the random blits and in the directed cases, and judges it by whether memory holds exactly the reference model's image of a copy made to the newly written address. A related collision, a register write in the very first busy cycle of a zero-size blit, is judged by reading the width back after completion.

// File: rtl/rop_blit_engine.sv
module rop_blit_engine #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [11:0]   reg_wdata,
  output logic [11:0]   reg_rdata,
  output logic          busy,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [23:0]   mem_addr,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata
);
  localparam int AW = 24;

  typedef enum logic [2:0] {ST_IDLE, ST_SRC, ST_DST, ST_WAIT, ST_WR} st_t;
  st_t state;

  logic [5:0]    ctrl;
  logic [AW-1:0] src, dst, s_row, s_ptr, d_row, d_ptr;
  logic [11:0]   wid, hgt, pitch, tcol, col, row;
  logic [3:0]    rop;
  logic [PW-1:0] sq, dq;

  function automatic logic [PW-1:0] rop_f(input logic [3:0] c, input logic [PW-1:0] s, input logic [PW-1:0] d);
    case (c)
      4'd0:  return '0;
      4'd1:  return s & d;
      4'd2:  return s & ~d;
      4'd3:  return s;
      4'd4:  return ~s & d;
      4'd5:  return d;
      4'd6:  return s ^ d;
      4'd7:  return s | d;
      4'd8:  return ~(s | d);
      4'd9:  return ~(s ^ d);
      4'd10: return ~d;
      4'd11: return s | ~d;
      4'd12: return ~s;
      4'd13: return ~s | d;
      4'd14: return ~(s & d);
      default: return '1;
    endcase
  endfunction

  assign busy = (state != ST_IDLE);

  wire idle_wr   = reg_we && !busy;
  wire start     = idle_wr && ((reg_addr == 4'd0 && reg_wdata[11]) || (reg_addr == 4'd4 && ctrl[4]));
  wire [AW-1:0] dst_go = (reg_addr == 4'd4) ? {reg_wdata, dst[11:0]} : dst;
  wire empty     = (wid == 12'd0) || (hgt == 12'd0);
  wire last_col  = (col == wid - 12'd1);
  wire last      = last_col && (row == hgt - 12'd1);
  wire [AW-1:0] step  = ctrl[0] ? {AW{1'b1}} : {{(AW-1){1'b0}}, 1'b1};
  wire [AW-1:0] pstep = ctrl[0] ? -{12'd0, pitch} : {12'd0, pitch};
  wire match     = (dq == tcol[PW-1:0]);
  wire keep      = !ctrl[1] || (match == ctrl[2]);

  assign mem_req   = (state == ST_SRC && !empty) || state == ST_DST || (state == ST_WR && keep);
  assign mem_we    = (state == ST_WR) && keep;
  assign mem_addr  = (state == ST_SRC) ? s_ptr : d_ptr;
  assign mem_wdata = rop_f(rop, sq, dq);

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = {busy, 5'd0, ctrl};
      4'd1: reg_rdata = src[11:0];
      4'd2: reg_rdata = src[23:12];
      4'd3: reg_rdata = dst[11:0];
      4'd4: reg_rdata = dst[23:12];
      4'd5: reg_rdata = wid;
      4'd6: reg_rdata = hgt;
      4'd7: reg_rdata = pitch;
      4'd8: reg_rdata = {8'd0, rop};
      4'd9: reg_rdata = tcol;
      default: reg_rdata = 12'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctrl <= '0; src <= '0; dst <= '0; wid <= '0; hgt <= '0; pitch <= '0; tcol <= '0; rop <= '0;
      s_row <= '0; s_ptr <= '0; d_row <= '0; d_ptr <= '0; col <= '0; row <= '0;
      sq <= '0; dq <= '0; irq <= 1'b0;
    end else begin
      if (idle_wr) begin
        case (reg_addr)
          4'd0: begin ctrl <= reg_wdata[5:0]; irq <= 1'b0; end
          4'd1: src[11:0]  <= reg_wdata;
          4'd2: src[23:12] <= reg_wdata;
          4'd3: dst[11:0]  <= reg_wdata;
          4'd4: dst[23:12] <= reg_wdata;
          4'd5: wid   <= reg_wdata;
          4'd6: hgt   <= reg_wdata;
          4'd7: pitch <= reg_wdata;
          4'd8: rop   <= reg_wdata[3:0];
          4'd9: tcol  <= reg_wdata;
          default: ;
        endcase
      end
      if (start) begin
        state <= ST_SRC;
        s_row <= src;    s_ptr <= src;
        d_row <= dst_go; d_ptr <= dst_go;
        col <= '0; row <= '0;
      end
      case (state)
        ST_SRC: if (empty) begin
                  state <= ST_IDLE;
                  irq   <= ctrl[5];
                end else state <= ST_DST;
        ST_DST:  begin sq <= mem_rdata; state <= ST_WAIT; end
        ST_WAIT: begin dq <= mem_rdata; state <= ST_WR; end
        ST_WR: begin
          if (last) begin
            state <= ST_IDLE;
            irq   <= ctrl[5];
            if (ctrl[3]) dst <= d_ptr + step;
          end else begin
            state <= ST_SRC;
            if (last_col) begin
              col <= '0; row <= row + 12'd1;
              s_row <= s_row + pstep; s_ptr <= s_row + pstep;
              d_row <= d_row + pstep; d_ptr <= d_row + pstep;
            end else begin
              col <= col + 12'd1;
              s_ptr <= s_ptr + step;
              d_ptr <= d_ptr + step;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rop_blit_checker.sv
module rop_blit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [11:0] reg_wdata,
  input logic        busy,
  input logic        irq,
  input logic        mem_req,
  input logic        mem_we,
  input logic [5:0]  ctrl_q,
  input logic [11:0] wid_q
);
  p_mem_busy_r6: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  p_we_req_r5: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_req);
  p_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 4'd0 && reg_wdata[11]) |=> busy);
  p_quick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 4'd4 && ctrl_q[4]) |=> busy);
  p_irq_end_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $fell(busy));
  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ctrl_q[5]);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n) (busy && reg_we) |=> $stable(wid_q));
endmodule

bind rop_blit_engine rop_blit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .ctrl_q(ctrl), .wid_q(wid)
);

// File: tb/tb_rop_blit_engine.sv
module tb_rop_blit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [11:0] reg_wdata = 12'd0;
  logic [11:0] reg_rdata;
  logic busy, irq, mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [MW];
  logic [7:0] exp_mem [MW];
  int vecs = 0, errs = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rop_blit_engine #(.PW(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    else mem_rdata <= mem[mem_addr[11:0]];
  end

  function automatic logic [7:0] ref_op(input int c, input logic [7:0] s, input logic [7:0] d);
    case (c)
      0: return 8'h00;      1: return s & d;     2: return s & ~d;    3: return s;
      4: return ~s & d;     5: return d;         6: return s ^ d;     7: return s | d;
      8: return ~(s | d);   9: return ~(s ^ d);  10: return ~d;       11: return s | ~d;
      12: return ~s;        13: return ~s | d;   14: return ~(s & d); default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d[11:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = a[3:0];
    #1;
    v = reg_rdata;
  endtask

  // ctl bits: 0 reverse, 1 transparency, 2 polarity, 3 update, 5 irq enable
  task automatic blit(input int sa, input int da, input int w, input int h, input int p,
                      input int op, input int ctl, input bit quick, input int tc);
    int v, cyc, lastd, endd, mism, first;
    bit rev;
    rev = ctl[0];
    for (int i = 0; i < MW; i++) exp_mem[i] = mem[i];
    endd = da;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int sp, dp;
        logic [7:0] s, d;
        bit m, kp;
        sp = rev ? sa - r*p - c : sa + r*p + c;
        dp = rev ? da - r*p - c : da + r*p + c;
        s = exp_mem[sp & 12'hFFF];
        d = exp_mem[dp & 12'hFFF];
        m = (d == tc[7:0]);
        kp = !ctl[1] || (m == ctl[2]);
        if (kp) exp_mem[dp & 12'hFFF] = ref_op(op, s, d);
        lastd = dp;
        if (ctl[3]) endd = rev ? lastd - 1 : lastd + 1;
      end
    wr(0, (ctl & 6'h2F) | (quick ? 16 : 0));
    wr(1, sa & 12'hFFF); wr(2, sa >> 12); wr(3, da & 12'hFFF);
    wr(5, w); wr(6, h); wr(7, p); wr(8, op); wr(9, tc);
    rd(1, v); check(v == (sa & 12'hFFF), "R1 src low readback", v, sa & 12'hFFF);
    rd(7, v); check(v == p, "R1 pitch readback", v, p);
    if (quick) wr(4, da >> 12);
    else begin wr(4, da >> 12); wr(0, (ctl & 6'h2F) | 12'h800); end
    rd(0, v);
    check(busy && v[11], quick ? "R7 quick start busy" : "R6 start busy", {busy, v[11]}, 3);
    reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = ~w[11:0];
    @(negedge clk);
    reg_we = 1'b0;
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
    check(!busy, "R6 busy clears", busy, 0);
    mism = 0; first = -1;
    for (int i = 0; i < MW; i++) if (mem[i] !== exp_mem[i]) begin mism++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    check(mism == 0, (w == 0 || h == 0) ? "R11 empty blit memory" :
          rev ? "R4/R2/R5/R8 reverse image" : "R3/R2/R5/R8 forward image",
          mem[first], exp_mem[first]);
    check(irq == ctl[5], "R9 completion irq", irq, ctl[5]);
    rd(3, v); check(v == (endd & 12'hFFF), "R10 dest low after blit", v, endd & 12'hFFF);
    rd(4, v); check(v == ((endd >> 12) & 12'hFFF), "R10 dest high after blit", v, (endd >> 12) & 12'hFFF);
    rd(5, v); check(v == w, "R12 width write ignored while busy", v, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < MW; i++) mem[i] = 8'($urandom % 4);
    repeat (3) @(negedge clk);
    check(!busy && !irq && !mem_req, "R6 reset idle", {busy, irq, mem_req}, 0);
    rd(0, v); check(v == 0, "R1 control reset value", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: overlapping forward and reverse shifts, zero sizes, transparency polarity
    blit(400, 401, 6, 1, 16, 3, 6'h28, 0, 0);
    blit(2610, 2611, 6, 2, 20, 3, 6'h29, 0, 0);
    blit(600, 700, 0, 3, 16, 15, 6'h28, 1, 0);
    blit(600, 700, 4, 0, 16, 15, 6'h20, 0, 0);
    blit(800, 900, 5, 4, 32, 12, 6'h22, 1, 2);
    blit(800, 900, 5, 4, 32, 6, 6'h26, 0, 1);
    blit(1000, 1000, 3, 3, 24, 10, 6'h09, 1, 0);
    for (int op = 0; op < 16; op++) blit(1200 + op*8, 1400 + op*8, 4, 2, 40, op, 6'h00, op[0], 0);
    for (int n = 0; n < 50; n++) begin
      int w, h, p, ctl, sa, da, tc;
      w = $urandom % 7; h = $urandom % 6; p = 8 + $urandom % 33;
      ctl = $urandom % 64;
      sa = ctl[0] ? 2500 + $urandom % 1000 : 300 + $urandom % 1200;
      da = sa + ($urandom % 41) - 20;
      tc = $urandom % 4;
      blit(sa, da, w, h, p, $urandom % 16, ctl, $urandom % 2, tc);
    end
    summary();
  end
endmodule